// File: doc/BRIEF.md
# Sub-Audio Tone Period Detector with Squelch Gating

This block decides, in the digital domain, whether a received squared-up sub-audio signal carries the tone selected by a 6-bit code. It counts clock cycles between successive rising edges of a 1-bit zero-crossing input. It then tests each measured period against a narrow window placed around the period expected for the selected code.

The results of those tests drive a raw per-period detect flag and a debounced decode flag. The decode flag uses separate thresholds for asserting and for releasing. Mode inputs for receive/transmit and for listen override combine with the decode flag to enable the receive audio, transmit audio and tone-output paths. Codes at or above the number of supported tones act as a "no tone" selection.

Periods are expressed in clock cycles and the defaults are scaled down so that runs stay short. A real deployment sets the expected-period parameters for the actual tone set and clock rate.

Top module: `tone_period_detector`

## Requirements
- R1: The measured period is the number of clock cycles between two consecutive sampled rising edges of `zc_i`. The first rising edge after reset or after a clear only arms the measurement and yields no result.
- R2: For code k below NUM_TONES, the expected period is E = MAX_PERIOD − k·PERIOD_STEP and the tolerance is T = E >> TOL_SHIFT. A period P is a hit when E−T ≤ P ≤ E+T and a miss otherwise. With the defaults, code 0 accepts 397..403, and the centre of code 1 (394) is a miss for code 0.
- R3: `raw_detect_o` becomes 1 after a hit and 0 after a miss. It updates on the second clock edge after the rising edge of `zc_i` is sampled.
- R4: `decode_o` asserts on the ASSERT_HITS-th consecutive hit (default 12). Any miss before that point restarts the count.
- R5: Once asserted, `decode_o` releases only on the RELEASE_MISSES-th consecutive miss (default 7). A hit in between restarts the miss count.
- R6: If no rising edge arrives while the cycle count reaches 2·MAX_PERIOD, the block counts a miss, restarts the count and disarms. This repeats for as long as the input stays silent.
- R7: A change of `tone_code_i` or `rx_i` clears the measurement, the raw flag and the decode flag on the next clock edge. A rising edge in that same cycle is ignored.
- R8: With `rx_i`=0 (transmit): `tx_audio_en_o`=1 and `rx_audio_en_o`=0. `raw_detect_o` and `decode_o` stay 0. `tone_out_en_o`=1 unless the no-tone code is selected.
- R9: With `rx_i`=1 (receive): `tx_audio_en_o`=0 and `tone_out_en_o`=0. `rx_audio_en_o` = `decode_o` OR `ptl_i` OR no-tone.
- R10: A code ≥ NUM_TONES (47) selects no-tone. In receive mode the detector is then held clear and both detect flags stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| zc_i | input | 1 | Squared sub-audio zero-crossing signal |
| tone_code_i | input | 6 | Selected tone code; ≥ NUM_TONES means no tone |
| rx_i | input | 1 | 1 = receive, 0 = transmit |
| ptl_i | input | 1 | Listen override in receive |
| raw_detect_o | output | 1 | Result of the last period test |
| decode_o | output | 1 | Debounced tone decode flag |
| rx_audio_en_o | output | 1 | Receive audio path enable |
| tx_audio_en_o | output | 1 | Transmit audio path enable |
| tone_out_en_o | output | 1 | Tone output enable |

## Verification
A code change and a rising edge of `zc_i` can land in the same cycle. In that case the clear must win: the edge must neither produce a result nor arm the measurement. The bench provokes this collision by switching from a decoded tone to a new code on the very clock that raises `zc_i`. It then expects both flags to read 0 two edges later. It also expects the next edge to only arm the measurement, so that decode returns exactly twelve hits after that.

// File: rtl/tpd_pkg.sv
package tpd_pkg;
  typedef struct packed {
    logic rx_audio;
    logic tx_audio;
    logic tone_out;
  } path_en_t;

  function automatic int unsigned expected_period(int unsigned code, int unsigned max_p,
                                                  int unsigned step);
    return max_p - code * step;
  endfunction
endpackage

// File: rtl/tpd_period_counter.sv
module tpd_period_counter #(
  parameter int unsigned LIMIT = 800,
  localparam int unsigned CW = $clog2(LIMIT + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          zc_i,
  output logic          meas_o,
  output logic [CW-1:0] period_o,
  output logic          timeout_o
);
  logic          zc_q, armed_q;
  logic [CW-1:0] cnt_q;
  logic          rise, at_limit;

  assign rise     = zc_i & ~zc_q;
  assign at_limit = (cnt_q == CW'(LIMIT));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      zc_q      <= 1'b0;
      armed_q   <= 1'b0;
      cnt_q     <= CW'(1);
      meas_o    <= 1'b0;
      period_o  <= '0;
      timeout_o <= 1'b0;
    end else begin
      zc_q      <= zc_i;
      meas_o    <= 1'b0;
      timeout_o <= 1'b0;
      if (clear_i) begin
        armed_q <= 1'b0;
        cnt_q   <= CW'(1);
      end else if (rise) begin
        armed_q <= 1'b1;
        cnt_q   <= CW'(1);
        if (armed_q) begin
          meas_o   <= 1'b1;
          period_o <= cnt_q;
        end
      end else if (at_limit) begin
        armed_q   <= 1'b0;
        cnt_q     <= CW'(1);
        timeout_o <= 1'b1;
      end else begin
        cnt_q <= cnt_q + CW'(1);
      end
    end
  end

  AST_CNT_BOUNDED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != '0) && (cnt_q <= CW'(LIMIT))); // R6
  AST_TIMEOUT_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (at_limit && !rise && !clear_i) |=> (cnt_q == CW'(1)) && timeout_o); // R6
endmodule

// File: rtl/tpd_window_match.sv
module tpd_window_match #(
  parameter int unsigned CODE_W     = 6,
  parameter int unsigned CW         = 10,
  parameter int unsigned MAX_PERIOD = 400,
  parameter int unsigned STEP       = 6,
  parameter int unsigned TOL_SHIFT  = 7
) (
  input  logic [CODE_W-1:0] code_i,
  input  logic [CW-1:0]     period_i,
  output logic              hit_o
);
  logic [31:0] exp_w, tol_w, per_w;

  always_comb begin
    exp_w = 32'(tpd_pkg::expected_period(32'(code_i), MAX_PERIOD, STEP));
    tol_w = exp_w >> TOL_SHIFT;
    per_w = 32'(period_i);
    hit_o = (per_w >= exp_w - tol_w) && (per_w <= exp_w + tol_w);
  end
endmodule

// File: rtl/tpd_decode_hyst.sv
module tpd_decode_hyst #(
  parameter int unsigned ASSERT_HITS    = 12,
  parameter int unsigned RELEASE_MISSES = 7,
  localparam int unsigned HW = $clog2(ASSERT_HITS + 1),
  localparam int unsigned MW = $clog2(RELEASE_MISSES + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic hit_i,
  input  logic miss_i,
  output logic raw_o,
  output logic decode_o
);
  logic [HW-1:0] hits_q;
  logic [MW-1:0] misses_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hits_q   <= '0;
      misses_q <= '0;
      raw_o    <= 1'b0;
      decode_o <= 1'b0;
    end else if (clear_i) begin
      hits_q   <= '0;
      misses_q <= '0;
      raw_o    <= 1'b0;
      decode_o <= 1'b0;
    end else if (hit_i) begin
      raw_o    <= 1'b1;
      misses_q <= '0;
      if (hits_q == HW'(ASSERT_HITS - 1)) decode_o <= 1'b1;
      if (hits_q < HW'(ASSERT_HITS)) hits_q <= hits_q + HW'(1);
    end else if (miss_i) begin
      raw_o  <= 1'b0;
      hits_q <= '0;
      if (misses_q == MW'(RELEASE_MISSES - 1)) decode_o <= 1'b0;
      if (misses_q < MW'(RELEASE_MISSES)) misses_q <= misses_q + MW'(1);
    end
  end

  AST_HIT_MISS_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hit_i && miss_i)); // R3
  AST_DEC_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(decode_o) |-> $past(hit_i)); // R4
  AST_DEC_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(decode_o) |-> ($past(miss_i) || $past(clear_i))); // R5
endmodule

// File: rtl/tone_period_detector.sv
module tone_period_detector #(
  parameter int unsigned NUM_TONES      = 47,
  parameter int unsigned CODE_W         = 6,
  parameter int unsigned MAX_PERIOD     = 400,
  parameter int unsigned PERIOD_STEP    = 6,
  parameter int unsigned TOL_SHIFT      = 7,
  parameter int unsigned ASSERT_HITS    = 12,
  parameter int unsigned RELEASE_MISSES = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              zc_i,
  input  logic [CODE_W-1:0] tone_code_i,
  input  logic              rx_i,
  input  logic              ptl_i,
  output logic              raw_detect_o,
  output logic              decode_o,
  output logic              rx_audio_en_o,
  output logic              tx_audio_en_o,
  output logic              tone_out_en_o
);
  import tpd_pkg::*;

  localparam int unsigned LIMIT = 2 * MAX_PERIOD;
  localparam int unsigned CW    = $clog2(LIMIT + 1);

  logic [CODE_W-1:0] code_q;
  logic              rx_q;
  logic              notone, change, clear;
  logic              meas, timeout, match, hit, miss;
  logic [CW-1:0]     period;
  path_en_t          path;

  assign notone = (32'(tone_code_i) >= NUM_TONES);
  assign change = (tone_code_i != code_q) || (rx_i != rx_q);
  assign clear  = change || !rx_i || notone;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q <= '0;
      rx_q   <= 1'b1;
    end else begin
      code_q <= tone_code_i;
      rx_q   <= rx_i;
    end
  end

  tpd_period_counter #(.LIMIT(LIMIT)) u_cnt (
    .clk_i, .rst_ni, .clear_i(clear), .zc_i,
    .meas_o(meas), .period_o(period), .timeout_o(timeout)
  );

  tpd_window_match #(
    .CODE_W(CODE_W), .CW(CW), .MAX_PERIOD(MAX_PERIOD),
    .STEP(PERIOD_STEP), .TOL_SHIFT(TOL_SHIFT)
  ) u_win (
    .code_i(tone_code_i), .period_i(period), .hit_o(match)
  );

  assign hit  = meas & match;
  assign miss = (meas & ~match) | timeout;

  tpd_decode_hyst #(.ASSERT_HITS(ASSERT_HITS), .RELEASE_MISSES(RELEASE_MISSES)) u_hyst (
    .clk_i, .rst_ni, .clear_i(clear), .hit_i(hit), .miss_i(miss),
    .raw_o(raw_detect_o), .decode_o(decode_o)
  );

  always_comb begin
    path.rx_audio = rx_i & (decode_o | ptl_i | notone);
    path.tx_audio = ~rx_i;
    path.tone_out = ~rx_i & ~notone;
  end

  assign rx_audio_en_o = path.rx_audio;
  assign tx_audio_en_o = path.tx_audio;
  assign tone_out_en_o = path.tone_out;

  AST_TX_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rx_i && $past(!rx_i)) |-> (!decode_o && !raw_detect_o)); // R8
  AST_CHANGE_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(change) |-> (!decode_o && !raw_detect_o)); // R7
  AST_NOTONE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(notone) |-> !decode_o); // R10
endmodule

// File: tb/tone_period_detector_tb.sv
`timescale 1ns/1ps
module tone_period_detector_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       zc_i = 1'b0;
  logic [5:0] tone_code_i = 6'd0;
  logic       rx_i = 1'b1;
  logic       ptl_i = 1'b0;
  logic       raw_detect_o, decode_o, rx_audio_en_o, tx_audio_en_o, tone_out_en_o;

  always #4 clk_i = ~clk_i;

  tone_period_detector u_dut (
    .clk_i, .rst_ni, .zc_i, .tone_code_i, .rx_i, .ptl_i,
    .raw_detect_o, .decode_o, .rx_audio_en_o, .tx_audio_en_o, .tone_out_en_o
  );

  typedef struct {
    logic  raw;
    logic  dec;
    string tag;
  } exp_t;

  exp_t q[$];
  event item_ev;
  int   total = 0, bad = 0;
  bit   done = 0;

  // reference model state
  bit m_on = 1, m_armed = 0, m_raw = 0, m_dec = 0;
  int m_hits = 0, m_miss = 0, prev_p = 0;

  task automatic chk(string tag, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_armed = 0; m_raw = 0; m_dec = 0; m_hits = 0; m_miss = 0;
  endtask

  task automatic model_rise(int p);
    int e, tol;
    bit h;
    if (!m_on) begin
      m_raw = 0; m_dec = 0;
    end else if (!m_armed) begin
      m_armed = 1;
    end else begin
      e   = 400 - 6 * int'(tone_code_i);
      tol = e / 128;
      h   = (prev_p >= e - tol) && (prev_p <= e + tol);
      if (h) begin
        m_raw = 1; m_miss = 0;
        if (m_hits < 12) m_hits++;
        if (m_hits == 12) m_dec = 1;
      end else begin
        m_raw = 0; m_hits = 0;
        if (m_miss < 7) m_miss++;
        if (m_miss == 7) m_dec = 0;
      end
    end
    prev_p = p;
  endtask

  task automatic push(string tag);
    exp_t it;
    it.raw = m_raw; it.dec = m_dec; it.tag = tag;
    q.push_back(it);
    -> item_ev;
  endtask

  task automatic wave(int p, string tag);
    @(negedge clk_i);
    zc_i = 1'b1;
    model_rise(p);
    push(tag);
    repeat (p / 2) @(negedge clk_i);
    zc_i = 1'b0;
    repeat (p - p / 2 - 1) @(negedge clk_i);
  endtask

  task automatic waves(int n, int p, string tag);
    for (int i = 0; i < n; i++) wave(p, tag);
  endtask

  task automatic wave_chg(int p, logic [5:0] code, string tag);
    @(negedge clk_i);
    zc_i = 1'b1;
    tone_code_i = code;
    model_reset();
    prev_p = p;
    push(tag);
    repeat (p / 2) @(negedge clk_i);
    zc_i = 1'b0;
    repeat (p - p / 2 - 1) @(negedge clk_i);
  endtask

  task automatic set_mode(logic [5:0] code, logic rx);
    @(negedge clk_i);
    tone_code_i = code;
    rx_i = rx;
    model_reset();
    m_on = rx && (code < 6'd47);
    @(negedge clk_i);
  endtask

  // monitor: pops expected flags two edges after each driven rising edge
  initial begin
    forever begin
      exp_t it;
      @(item_ev);
      repeat (2) @(negedge clk_i);
      it = q.pop_front();
      chk({it.tag, " R3 raw"}, raw_detect_o, it.raw);
      chk({it.tag, " decode"}, decode_o, it.dec);
    end
  end

  initial begin
    #1600000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=1 exp=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("reset raw", raw_detect_o, 1'b0);
    chk("reset decode", decode_o, 1'b0);
    chk("reset R9 rx_audio", rx_audio_en_o, 1'b0);
    chk("reset R9 tx_audio", tx_audio_en_o, 1'b0);
    chk("reset R9 tone_out", tone_out_en_o, 1'b0);

    // R1 R4: arm then twelve hits
    waves(13, 400, "R1 R4 acquire");
    chk("R4 decoded", decode_o, 1'b1);
    chk("R9 audio on decode", rx_audio_en_o, 1'b1);

    // R2 window edges, R5 misses below release count
    wave(403, "R2 centre");
    wave(397, "R2 upper edge");
    wave(404, "R2 lower edge");
    wave(396, "R2 R5 over upper");
    wave(400, "R2 R5 under lower");
    wave(400, "R5 hit resets misses");

    // R2 adjacent code period rejected, R5 release on 7th miss
    waves(8, 394, "R2 R5 adjacent");
    chk("R5 released", decode_o, 1'b0);

    // R4 miss before threshold restarts the count
    waves(11, 400, "R4 build");
    wave(394, "R4 eleventh hit");
    wave(400, "R4 interrupting miss");
    chk("R4 no early decode", decode_o, 1'b0);
    waves(13, 400, "R4 reacquire");
    chk("R4 decoded again", decode_o, 1'b1);

    // R6 silent input: misses every 800 cycles
    repeat (5151) @(negedge clk_i);
    chk("R6 held after six timeouts", decode_o, 1'b1);
    chk("R6 raw cleared by timeout", raw_detect_o, 1'b0);
    repeat (60) @(negedge clk_i);
    chk("R6 released after seven timeouts", decode_o, 1'b0);
    model_reset();

    // R9 listen override
    ptl_i = 1'b1; #1;
    chk("R9 ptl opens audio", rx_audio_en_o, 1'b1);
    @(negedge clk_i);
    ptl_i = 1'b0; #1;
    chk("R9 ptl off closes audio", rx_audio_en_o, 1'b0);

    // R7 code change; collision of change and rising edge
    set_mode(6'd5, 1'b1);
    waves(13, 370, "R7 acquire code5");
    chk("R4 decoded code5", decode_o, 1'b1);
    wave_chg(364, 6'd6, "R7 change with edge");
    waves(12, 364, "R7 first edge arms");
    chk("R7 not yet decoded", decode_o, 1'b0);
    wave(364, "R7 twelfth hit");
    chk("R7 decoded code6", decode_o, 1'b1);

    // R8 transmit
    set_mode(6'd6, 1'b0);
    chk("R8 tx_audio", tx_audio_en_o, 1'b1);
    chk("R8 rx_audio", rx_audio_en_o, 1'b0);
    chk("R8 tone_out", tone_out_en_o, 1'b1);
    chk("R8 decode cleared", decode_o, 1'b0);
    waves(4, 364, "R8 tx ignores input");
    set_mode(6'd50, 1'b0);
    chk("R8 R10 notone tone_out", tone_out_en_o, 1'b0);
    chk("R8 R10 notone tx_audio", tx_audio_en_o, 1'b1);

    // R10 no-tone in receive
    set_mode(6'd50, 1'b1);
    chk("R10 rx_audio", rx_audio_en_o, 1'b1);
    chk("R10 tone_out", tone_out_en_o, 1'b0);
    chk("R10 tx_audio", tx_audio_en_o, 1'b0);
    waves(4, 400, "R10 detector held");

    repeat (4) @(negedge clk_i);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule